// File: doc/BRIEF.md
# TDM Frame and Slot Timing Generator

This block produces the frame-level and bit-level timing for a serial audio port. It counts bit periods, using a selected bit-clock edge as the advancing event. From the bit count within the frame it derives a frame-sync output, the index of the current slot, the index of the current bit within that slot, and a strobe that marks which bit periods carry valid sample data. The counting, sync and strobe logic is the same for I2S, left-justified, right-justified, both PCM variants and multi-slot TDM framing. The framing code changes only how the valid window is placed in a slot. A serializer next to this block uses the launch and sample strobes to shift data out and in.

All geometry fields are independent of each other: frame length, sync width, sync polarity, a one-bit early-sync option, slot count, slot size, data size and first-bit offset. Each field is taken into a shadow copy only when a frame begins, so the frame already in progress keeps its shape. As master, the block wraps its frame on its own. As slave, it restarts the frame on the active edge of an external frame-sync input and ignores the frame length.

Top module: `tdm_frame_gen`

## Requirements
- R1: In master mode the frame counter wraps after frame_len_m1_i+1 bit periods. After each wrap, and after each slave resynchronisation, frame_start_o pulses high for one clock and the slot and bit indices read 0.
- R2: With sync_early_i=0, the frame sync is active for positions 0 through sync_len_m1_i of the frame. fs_o equals the active state when sync_pol_i=1 and its inverse when sync_pol_i=0.
- R3: With sync_early_i=1, the sync window moves one bit earlier: it is active at the last position of the frame (frame_len_m1_i) and at positions below sync_len_m1_i.
- R4: bit_idx_o counts 0 to slot_size_m1_i and then returns to 0, and slot_idx_o then steps by one. One advancing bit-clock edge moves the indices by exactly one bit.
- R5: For mode codes other than 2, data_valid_o is high for bits b of a slot with first_bit_ofs_i <= b < first_bit_ofs_i+data_size_m1_i+1.
- R6: For mode code 2 (right-justified), data_valid_o covers the last data_size_m1_i+1 bits of each slot, and the first-bit offset is ignored.
- R7: Bit periods after the last slot (slot_cnt_m1_i+1 slots) never assert data_valid_o, and slot_idx_o holds at the last slot index during them.
- R8: A configuration change made mid-frame has no effect until the next frame wrap. The new values take effect at position 0 of the next frame.
- R9: In slave mode (master_i=0), an active edge of ext_fs_i sampled on an advancing bit-clock edge restarts the frame. The active level is high when sync_pol_i=1. Without such an edge the counter keeps running past frame_len_m1_i.
- R10: Each edge select uses 1 for the rising edge and 0 for the falling edge. fs_edge_sel_i picks the edge that advances the counters. tx_launch_o and rx_sample_o equal data_valid_o gated by the edge picked by tx_edge_sel_i and rx_edge_sel_i.
- R11: After reset the slot and bit indices are 0, and frame_start_o, tx_launch_o and rx_sample_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bclk_rise_i | input | 1 | One-clock pulse at each bit-clock rising edge |
| bclk_fall_i | input | 1 | One-clock pulse at each bit-clock falling edge |
| master_i | input | 1 | 1 = generate frames, 0 = follow ext_fs_i |
| fs_edge_sel_i | input | 1 | Edge that advances the counters (1 rise, 0 fall) |
| tx_edge_sel_i | input | 1 | Edge for the launch strobe |
| rx_edge_sel_i | input | 1 | Edge for the sample strobe |
| mode_i | input | 3 | Framing code; 2 selects right-justified placement |
| frame_len_m1_i | input | 9 | Bits per frame minus one |
| sync_len_m1_i | input | 8 | Sync width minus one |
| sync_pol_i | input | 1 | 1 = sync active high |
| sync_early_i | input | 1 | Sync leads the first bit by one period |
| slot_cnt_m1_i | input | 4 | Slots per frame minus one |
| slot_size_m1_i | input | 6 | Bits per slot minus one |
| data_size_m1_i | input | 5 | Valid bits per slot minus one |
| first_bit_ofs_i | input | 5 | Leading bits skipped in each slot |
| ext_fs_i | input | 1 | External frame sync (slave) |
| fs_o | output | 1 | Frame sync |
| frame_start_o | output | 1 | One-clock pulse at frame start |
| slot_idx_o | output | 4 | Current slot |
| bit_idx_o | output | 6 | Current bit within slot |
| data_valid_o | output | 1 | Current bit carries data |
| tx_launch_o | output | 1 | Launch strobe |
| rx_sample_o | output | 1 | Sample strobe |

## Verification
The bench uses the package's default field widths: a 9-bit frame length, 16 slots and slots of up to 64 bits. Inside those widths it uses small geometries of 8 to 24 bits per frame with 2 to 4 slots, so every position of several whole frames is compared against a model. Frames longer than the slots they hold bring the past-the-last-slot region within reach. A 4-bit slave frame length set against a longer external sync period shows that the length is ignored. Swapping the edge selects covers both edge assignments.

// File: rtl/tdm_frame_pkg.sv
package tdm_frame_pkg;
  localparam int FLEN_W = 9;
  localparam int SYNC_W = 8;
  localparam int SCNT_W = 4;
  localparam int SSZ_W  = 6;
  localparam int DSZ_W  = 5;
  localparam int OFS_W  = 5;
  localparam int MODE_W = 3;
  localparam int NEDGE  = 3;

  typedef enum logic [MODE_W-1:0] {
    FMT_I2S  = 3'd0,
    FMT_LJ   = 3'd1,
    FMT_RJ   = 3'd2,
    FMT_PCMA = 3'd3,
    FMT_PCMB = 3'd4,
    FMT_TDM  = 3'd5
  } fmt_e;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic [FLEN_W-1:0] flen_m1;
    logic [SYNC_W-1:0] sync_m1;
    logic              pol;
    logic              early;
    logic [SCNT_W-1:0] scnt_m1;
    logic [SSZ_W-1:0]  ssz_m1;
    logic [DSZ_W-1:0]  dsz_m1;
    logic [OFS_W-1:0]  ofs;
  } cfg_t;
endpackage

// File: rtl/tdm_edge_pick.sv
module tdm_edge_pick #(
  parameter int N = 3
) (
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic [N-1:0] sel_i,
  output logic [N-1:0] tick_o
);
  for (genvar g = 0; g < N; g++) begin : g_pick
    assign tick_o[g] = sel_i[g] ? rise_i : fall_i;
  end
endmodule

// File: rtl/tdm_cfg_shadow.sv
module tdm_cfg_shadow
  import tdm_frame_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  cfg_t cfg_i,
  output cfg_t cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_o <= '0;
    else if (load_i) cfg_o <= cfg_i;
  end
endmodule

// File: rtl/tdm_pos_ctr.sv
module tdm_pos_ctr
  import tdm_frame_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              master_i,
  input  logic              ext_fs_i,
  input  cfg_t              cfg_i,
  output logic              wrap_o,
  output logic [FLEN_W-1:0] pos_o,
  output logic [SCNT_W-1:0] slot_o,
  output logic [SSZ_W-1:0]  bit_o,
  output logic              over_o,
  output logic              fstart_o
);
  logic [FLEN_W-1:0] pos_q;
  logic [SCNT_W-1:0] slot_q;
  logic [SSZ_W-1:0]  bit_q;
  logic              over_q, prev_q, fstart_q;
  logic              ext_act, ext_edge, last_pos, slot_end;

  assign ext_act  = cfg_i.pol ? ext_fs_i : ~ext_fs_i;
  assign ext_edge = ext_act & ~prev_q;
  assign last_pos = pos_q >= cfg_i.flen_m1;
  assign slot_end = bit_q == cfg_i.ssz_m1;
  assign wrap_o   = tick_i & (master_i ? last_pos : ext_edge);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q    <= '0;
      slot_q   <= '0;
      bit_q    <= '0;
      over_q   <= 1'b0;
      prev_q   <= 1'b0;
      fstart_q <= 1'b0;
    end else begin
      fstart_q <= wrap_o;
      if (tick_i) prev_q <= ext_act;
      if (wrap_o) begin
        pos_q  <= '0;
        slot_q <= '0;
        bit_q  <= '0;
        over_q <= 1'b0;
      end else if (tick_i) begin
        if (pos_q != {FLEN_W{1'b1}}) pos_q <= pos_q + 1'b1;
        if (slot_end) begin
          bit_q <= '0;
          if (slot_q == cfg_i.scnt_m1) over_q <= 1'b1;
          else if (!over_q)            slot_q <= slot_q + 1'b1;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end

  assign pos_o    = pos_q;
  assign slot_o   = slot_q;
  assign bit_o    = bit_q;
  assign over_o   = over_q;
  assign fstart_o = fstart_q;
endmodule

// File: rtl/tdm_slot_decode.sv
module tdm_slot_decode
  import tdm_frame_pkg::*;
(
  input  cfg_t              cfg_i,
  input  logic [FLEN_W-1:0] pos_i,
  input  logic [SSZ_W-1:0]  bit_i,
  input  logic              over_i,
  output logic              fs_o,
  output logic              valid_o
);
  localparam int PW = FLEN_W + 1;
  localparam int WW = SSZ_W + 2;

  logic [PW-1:0] p_x, s_x, l_x;
  logic [WW-1:0] b_x, d_x, o_x, z_x;
  logic          act, win_lj, win_rj;

  assign p_x = {1'b0, pos_i};
  assign s_x = {{(PW-SYNC_W){1'b0}}, cfg_i.sync_m1};
  assign l_x = {1'b0, cfg_i.flen_m1};
  assign act = cfg_i.early ? ((p_x == l_x) || (p_x < s_x)) : (p_x <= s_x);
  assign fs_o = cfg_i.pol ? act : ~act;

  assign b_x = {2'b00, bit_i};
  assign d_x = {{(WW-DSZ_W){1'b0}}, cfg_i.dsz_m1} + 1'b1;
  assign o_x = {{(WW-OFS_W){1'b0}}, cfg_i.ofs};
  assign z_x = {2'b00, cfg_i.ssz_m1};

  assign win_lj  = (b_x >= o_x) && (b_x < o_x + d_x);
  assign win_rj  = (b_x + d_x) > z_x;
  assign valid_o = ~over_i & ((cfg_i.mode == FMT_RJ) ? win_rj : win_lj);
endmodule

// File: rtl/tdm_frame_gen.sv
module tdm_frame_gen
  import tdm_frame_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bclk_rise_i,
  input  logic              bclk_fall_i,
  input  logic              master_i,
  input  logic              fs_edge_sel_i,
  input  logic              tx_edge_sel_i,
  input  logic              rx_edge_sel_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [FLEN_W-1:0] frame_len_m1_i,
  input  logic [SYNC_W-1:0] sync_len_m1_i,
  input  logic              sync_pol_i,
  input  logic              sync_early_i,
  input  logic [SCNT_W-1:0] slot_cnt_m1_i,
  input  logic [SSZ_W-1:0]  slot_size_m1_i,
  input  logic [DSZ_W-1:0]  data_size_m1_i,
  input  logic [OFS_W-1:0]  first_bit_ofs_i,
  input  logic              ext_fs_i,
  output logic              fs_o,
  output logic              frame_start_o,
  output logic [SCNT_W-1:0] slot_idx_o,
  output logic [SSZ_W-1:0]  bit_idx_o,
  output logic              data_valid_o,
  output logic              tx_launch_o,
  output logic              rx_sample_o
);
  logic [NEDGE-1:0] ticks;
  logic             fs_tick, wrap, start_q, over;
  logic [FLEN_W-1:0] pos;
  cfg_t             cfg_in, cfg_q;

  tdm_edge_pick #(.N(NEDGE)) u_pick (
    .rise_i (bclk_rise_i),
    .fall_i (bclk_fall_i),
    .sel_i  ({rx_edge_sel_i, tx_edge_sel_i, fs_edge_sel_i}),
    .tick_o (ticks)
  );
  assign fs_tick = ticks[0];

  assign cfg_in = '{mode: mode_i, flen_m1: frame_len_m1_i, sync_m1: sync_len_m1_i,
                    pol: sync_pol_i, early: sync_early_i, scnt_m1: slot_cnt_m1_i,
                    ssz_m1: slot_size_m1_i, dsz_m1: data_size_m1_i, ofs: first_bit_ofs_i};

  // shadow follows inputs until the first bit, then only at frame wraps
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      start_q <= 1'b0;
    else if (fs_tick) start_q <= 1'b1;
  end

  tdm_cfg_shadow u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (~start_q | wrap),
    .cfg_i  (cfg_in),
    .cfg_o  (cfg_q)
  );

  tdm_pos_ctr u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (fs_tick),
    .master_i (master_i),
    .ext_fs_i (ext_fs_i),
    .cfg_i    (cfg_q),
    .wrap_o   (wrap),
    .pos_o    (pos),
    .slot_o   (slot_idx_o),
    .bit_o    (bit_idx_o),
    .over_o   (over),
    .fstart_o (frame_start_o)
  );

  tdm_slot_decode u_dec (
    .cfg_i   (cfg_q),
    .pos_i   (pos),
    .bit_i   (bit_idx_o),
    .over_i  (over),
    .fs_o    (fs_o),
    .valid_o (data_valid_o)
  );

  assign tx_launch_o = ticks[1] & data_valid_o;
  assign rx_sample_o = ticks[2] & data_valid_o;
endmodule

// File: rtl/tdm_frame_chk.sv
module tdm_frame_chk
  import tdm_frame_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fs_tick,
  input logic              start_q,
  input cfg_t              cfg_q,
  input logic              frame_start_o,
  input logic [SCNT_W-1:0] slot_idx_o,
  input logic [SSZ_W-1:0]  bit_idx_o,
  input logic              data_valid_o,
  input logic              tx_launch_o,
  input logic              rx_sample_o
);
  a_r1_start_at_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> (slot_idx_o == '0 && bit_idx_o == '0));

  a_r4_bit_in_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_idx_o <= cfg_q.ssz_m1);

  a_r7_slot_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> slot_idx_o <= cfg_q.scnt_m1);

  a_r8_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_q && $past(start_q) && !frame_start_o) |-> $stable(cfg_q));

  a_r10_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fs_tick |=> ($stable(bit_idx_o) && $stable(slot_idx_o)));

  a_r10_tx_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_launch_o |-> data_valid_o);

  a_r10_rx_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_sample_o |-> data_valid_o);
endmodule

bind tdm_frame_gen tdm_frame_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fs_tick       (fs_tick),
  .start_q       (start_q),
  .cfg_q         (cfg_q),
  .frame_start_o (frame_start_o),
  .slot_idx_o    (slot_idx_o),
  .bit_idx_o     (bit_idx_o),
  .data_valid_o  (data_valid_o),
  .tx_launch_o   (tx_launch_o),
  .rx_sample_o   (rx_sample_o)
);

// File: tb/tb_tdm_frame_gen.sv
module tb_tdm_frame_gen;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic bclk_rise_i = 0, bclk_fall_i = 0, master_i = 1;
  logic fs_edge_sel_i = 0, tx_edge_sel_i = 0, rx_edge_sel_i = 1;
  logic [2:0] mode_i = 3'd5;
  logic [8:0] frame_len_m1_i = 9'd15;
  logic [7:0] sync_len_m1_i = 8'd2;
  logic sync_pol_i = 1, sync_early_i = 0, ext_fs_i = 0;
  logic [3:0] slot_cnt_m1_i = 4'd1;
  logic [5:0] slot_size_m1_i = 6'd7;
  logic [4:0] data_size_m1_i = 5'd3;
  logic [4:0] first_bit_ofs_i = 5'd1;
  logic fs_o, frame_start_o, data_valid_o, tx_launch_o, rx_sample_o;
  logic [3:0] slot_idx_o;
  logic [5:0] bit_idx_o;

  int total = 0, bad = 0;
  int exp_pos, ext_prev, exp_fst;
  int mc_mode, mc_flen, mc_sync, mc_pol, mc_early, mc_scnt, mc_ssz, mc_dsz, mc_ofs;
  string vtag;

  always #2.5 clk_i = ~clk_i;

  tdm_frame_gen dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic latch_mc();
    mc_mode = mode_i; mc_flen = frame_len_m1_i; mc_sync = sync_len_m1_i;
    mc_pol = sync_pol_i; mc_early = sync_early_i; mc_scnt = slot_cnt_m1_i;
    mc_ssz = slot_size_m1_i; mc_dsz = data_size_m1_i; mc_ofs = first_bit_ofs_i;
  endtask

  function automatic int e_over(int p); return (p / (mc_ssz + 1)) > mc_scnt; endfunction
  function automatic int e_slot(int p);
    return e_over(p) ? mc_scnt : p / (mc_ssz + 1);
  endfunction
  function automatic int e_bit(int p); return p % (mc_ssz + 1); endfunction
  function automatic int e_fs(int p);
    int a = mc_early ? (p == mc_flen || p < mc_sync) : (p <= mc_sync);
    return mc_pol ? a : !a;
  endfunction
  function automatic int e_valid(int p);
    int b = e_bit(p);
    if (e_over(p)) return 0;
    if (mc_mode == 2) return (b + mc_dsz + 1) > mc_ssz;
    return (b >= mc_ofs) && (b < mc_ofs + mc_dsz + 1);
  endfunction

  task automatic apply_reset();
    rst_ni = 0; bclk_rise_i = 0; bclk_fall_i = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
    latch_mc();
    exp_pos = 0; ext_prev = 0;
  endtask

  task automatic check_state(input string ftag);
    chk(fs_o == e_fs(exp_pos), ftag, fs_o, e_fs(exp_pos));
    chk(slot_idx_o == e_slot(exp_pos), "R4 slot", slot_idx_o, e_slot(exp_pos));
    chk(bit_idx_o == e_bit(exp_pos), "R4 bit", bit_idx_o, e_bit(exp_pos));
    chk(data_valid_o == e_valid(exp_pos), vtag, data_valid_o, e_valid(exp_pos));
  endtask

  // one bit period: rise pulse, fall pulse (counters advance on fall)
  task automatic do_bit(input string ftag);
    int v = e_valid(exp_pos);
    int act, edge_s;
    @(negedge clk_i); bclk_rise_i = 1; #1;
    chk(rx_sample_o == v, "R10 rx on rise", rx_sample_o, v);
    chk(tx_launch_o == 0, "R10 tx not on rise", tx_launch_o, 0);
    @(negedge clk_i); bclk_rise_i = 0; bclk_fall_i = 1; #1;
    chk(tx_launch_o == v, "R10 tx on fall", tx_launch_o, v);
    @(negedge clk_i); bclk_fall_i = 0;
    act = mc_pol ? ext_fs_i : !ext_fs_i;
    edge_s = act && !ext_prev;
    ext_prev = act;
    exp_fst = master_i ? (exp_pos >= mc_flen) : edge_s;
    if (exp_fst) begin exp_pos = 0; latch_mc(); end
    else if (exp_pos < 511) exp_pos++;
    #1;
    chk(frame_start_o == exp_fst, "R1 frame_start", frame_start_o, exp_fst);
    check_state(ftag);
  endtask

  task automatic t_reset();
    sync_pol_i = 1;
    rst_ni = 0;
    repeat (2) @(negedge clk_i);
    chk(slot_idx_o == 0 && bit_idx_o == 0, "R11 indices", {slot_idx_o, bit_idx_o}, 0);
    chk(frame_start_o == 0, "R11 frame_start", frame_start_o, 0);
    chk(tx_launch_o == 0 && rx_sample_o == 0, "R11 strobes", {tx_launch_o, rx_sample_o}, 0);
    apply_reset();
    chk(fs_o == 1, "R2 active-high at pos 0", fs_o, 1);
  endtask

  task automatic t_master();
    vtag = "R5 valid";
    apply_reset();
    check_state("R2 fs");
    for (int i = 0; i < 32; i++) do_bit("R2 fs");
  endtask

  task automatic t_early_low();
    sync_pol_i = 0; sync_early_i = 1; sync_len_m1_i = 8'd1;
    vtag = "R5 valid";
    apply_reset();
    for (int i = 0; i < 20; i++) do_bit("R3 early sync");
  endtask

  task automatic t_rj();
    sync_pol_i = 1; sync_early_i = 0; mode_i = 3'd2; data_size_m1_i = 5'd2;
    first_bit_ofs_i = 5'd4;
    vtag = "R6 right-justified";
    apply_reset();
    for (int i = 0; i < 16; i++) do_bit("R2 fs");
    mode_i = 3'd5;
  endtask

  task automatic t_past_slots();
    frame_len_m1_i = 9'd23; first_bit_ofs_i = 5'd0; data_size_m1_i = 5'd7;
    vtag = "R7 past last slot";
    apply_reset();
    for (int i = 0; i < 48; i++) do_bit("R2 fs");
  endtask

  task automatic t_midframe();
    frame_len_m1_i = 9'd15; data_size_m1_i = 5'd3; first_bit_ofs_i = 5'd1;
    sync_len_m1_i = 8'd2;
    vtag = "R8 valid";
    apply_reset();
    for (int i = 0; i < 5; i++) do_bit("R8 fs");
    frame_len_m1_i = 9'd7; sync_len_m1_i = 8'd5; first_bit_ofs_i = 5'd0;
    for (int i = 0; i < 27; i++) do_bit("R8 fs");
  endtask

  task automatic t_slave();
    master_i = 0; frame_len_m1_i = 9'd3; sync_len_m1_i = 8'd0;
    slot_cnt_m1_i = 4'd3; vtag = "R9 valid";
    apply_reset();
    for (int i = 0; i < 10; i++) do_bit("R9 fs");
    chk(bit_idx_o == 2 && slot_idx_o == 1, "R9 runs past length",
        {slot_idx_o, bit_idx_o}, {4'd1, 6'd2});
    ext_fs_i = 1; do_bit("R9 fs");
    chk(bit_idx_o == 0 && slot_idx_o == 0, "R9 resync", bit_idx_o, 0);
    do_bit("R9 fs");
    ext_fs_i = 0;
    for (int i = 0; i < 6; i++) do_bit("R9 fs");
    master_i = 1;
  endtask

  task automatic t_edges();
    fs_edge_sel_i = 1; tx_edge_sel_i = 1; rx_edge_sel_i = 0;
    first_bit_ofs_i = 5'd0; slot_cnt_m1_i = 4'd1; frame_len_m1_i = 9'd15;
    apply_reset();
    @(negedge clk_i); bclk_rise_i = 1; #1;
    chk(tx_launch_o == 1 && rx_sample_o == 0, "R10 swapped rise", {tx_launch_o, rx_sample_o}, 2);
    @(negedge clk_i); bclk_rise_i = 0; #1;
    chk(bit_idx_o == 1, "R10 advance on rise", bit_idx_o, 1);
    @(negedge clk_i); bclk_fall_i = 1; #1;
    chk(rx_sample_o == 1 && tx_launch_o == 0, "R10 swapped fall", {tx_launch_o, rx_sample_o}, 1);
    @(negedge clk_i); bclk_fall_i = 0; #1;
    chk(bit_idx_o == 1, "R10 no advance on fall", bit_idx_o, 1);
    fs_edge_sel_i = 0; tx_edge_sel_i = 0; rx_edge_sel_i = 1;
  endtask

  initial begin
    #(5.0 * 200000);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_master();
    t_early_low();
    t_rj();
    t_past_slots();
    t_midframe();
    t_slave();
    t_edges();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule